// File: doc/BRIEF.md
# Bus-Idle Automatic Power-Down Controller

This block watches the address-latch strobe of an 8-bit microcontroller bus and puts the device into a power-down state once the bus has gone quiet. The strobe is first brought into the local clock domain through a two-stage synchronizer. Any change in its synchronized level counts as bus activity, and so does an asserted chip-select input. Either one restarts an idle counter. When the counter has seen a fixed number of consecutive clock cycles without activity, default 15, it reaches its terminal count and holds there. While it sits at that count, the block is powered down.

While powered down, the block forces the flash, EEPROM and SRAM select outputs low and drops the bus-interface enable. It can also hold selected inputs of a downstream programmable logic array at zero. Two 8-bit control registers set the behaviour and are loaded through a simple write port. A bit in the first register enables the whole feature. Further bits in both registers choose which logic-array inputs are blocked during power-down. Any bus activity, clearing the enable bit, or reset brings the block back out of power-down.

Top module: `bus_idle_pdown`

## Requirements
- R1: After reset, `pwr_down` is 0, both control registers hold 0, all select and enable outputs follow their inputs, and `pla_out` equals `pla_in`.
- R2: Automatic power-down is enabled only while bit 1 of control register A is 1. While that bit is 0, `pwr_down` stays 0 no matter how long the bus is idle.
- R3: With the feature enabled, `pwr_down` goes to 1 after 15 consecutive clock edges at which no bus activity was seen. If the enable write lands at edge E and the bus is quiet, `pwr_down` is 0 after edge E+14 and 1 after edge E+15.
- R4: `strobe_in` passes through two synchronizer flops. A change is flagged when the two most recent synchronized samples differ. A level change on `strobe_in` sampled at edge N therefore restarts the idle count at edge N+2.
- R5: A strobe change ends power-down. If a change is first sampled at edge N while powered down, `pwr_down` is still 1 after edge N+1 and is 0 after edge N+2.
- R6: `cs_active` = 1 sampled at a clock edge counts as bus activity. `pwr_down` is 0 after that edge, and the idle count restarts.
- R7: While `pwr_down` is 1, `flash_sel`, `eeprom_sel`, `sram_sel` and `bus_en` are 0. Otherwise each equals its matching `*_in` input.
- R8: Logic-array gating works bit by bit. `pla_in[0]` is blocked by bit 4 of register A. `pla_in[1]` through `pla_in[5]` are blocked by bits 2 through 6 of register B. A blocked bit reads 0 on `pla_out` only while `pwr_down` is 1. Otherwise `pla_out` equals `pla_in`.
- R9: When `reg_wr` = 1 at a clock edge, `reg_wdata` is loaded into register A if `reg_sel` = 0, or into register B if `reg_sel` = 1. The new value takes effect after that edge. With `reg_wr` = 0 nothing is loaded, and a write to one register leaves the other unchanged.
- R10: Clearing the enable bit while powered down releases power-down. If the write lands at edge E, `pwr_down` is still 1 after E and 0 after E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous reset, active high |
| strobe_in | input | 1 | Address-latch strobe from the bus, asynchronous |
| cs_active | input | 1 | Chip select asserted, counts as bus activity |
| reg_wr | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 selects register A, 1 selects register B |
| reg_wdata | input | 8 | Write data |
| flash_sel_in | input | 1 | Flash select from the decoder |
| eeprom_sel_in | input | 1 | EEPROM select from the decoder |
| sram_sel_in | input | 1 | SRAM select from the decoder |
| bus_en_in | input | 1 | Bus interface enable request |
| pla_in | input | 6 | Inputs headed to the logic array |
| pwr_down | output | 1 | Power-down state |
| flash_sel | output | 1 | Gated flash select |
| eeprom_sel | output | 1 | Gated EEPROM select |
| sram_sel | output | 1 | Gated SRAM select |
| bus_en | output | 1 | Gated bus interface enable |
| pla_out | output | 6 | Gated logic-array inputs |

## Verification
The bench checks the exact cycle at which power-down starts. An off-by-one counter would show `pwr_down` one edge early or late relative to the enable write or the last strobe change. It also checks the release latency through the synchronizer. A design missing a flop, or one that compares the raw strobe, would release too soon. A design that ignored strobe changes would never release. The bench applies strobe patterns that toggle just faster and just slower than the idle limit, pulses the chip select, and clears the enable bit while powered down; each of these must end or prevent power-down. It also checks the bit-to-input mapping of the gating mask, so that a wrong field position or a register-select swap shows up as a wrong `pla_out` bit.

// File: rtl/bus_idle_pdown.sv
module bus_idle_pdown #(
  parameter int IDLE_CYCLES = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_in,
  input  logic       cs_active,
  input  logic       reg_wr,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       flash_sel_in,
  input  logic       eeprom_sel_in,
  input  logic       sram_sel_in,
  input  logic       bus_en_in,
  input  logic [5:0] pla_in,
  output logic       pwr_down,
  output logic       flash_sel,
  output logic       eeprom_sel,
  output logic       sram_sel,
  output logic       bus_en,
  output logic [5:0] pla_out
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(IDLE_CYCLES);

  logic [7:0]          ctl_a, ctl_b;
  logic [SYNC_STAGES:0] smp;
  logic [CW-1:0]       idle_cnt;
  logic                chg, busy, en;
  logic [5:0]          blk_mask;

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      ctl_a <= '0;
      ctl_b <= '0;
    end else if (reg_wr) begin
      if (reg_sel) ctl_b <= reg_wdata;
      else         ctl_a <= reg_wdata;
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) smp <= '0;
    else     smp <= {smp[SYNC_STAGES-1:0], strobe_in};

  assign chg  = smp[SYNC_STAGES] ^ smp[SYNC_STAGES-1];
  assign busy = chg | cs_active;
  assign en   = ctl_a[1];

  always_ff @(posedge clk or posedge rst)
    if (rst)                   idle_cnt <= '0;
    else if (!en || busy)      idle_cnt <= '0;
    else if (idle_cnt != TERM) idle_cnt <= idle_cnt + 1'b1;

  assign pwr_down   = (idle_cnt == TERM);
  assign flash_sel  = flash_sel_in  & ~pwr_down;
  assign eeprom_sel = eeprom_sel_in & ~pwr_down;
  assign sram_sel   = sram_sel_in   & ~pwr_down;
  assign bus_en     = bus_en_in     & ~pwr_down;

  assign blk_mask = {ctl_b[6:2], ctl_a[4]} & {6{pwr_down}};
  assign pla_out  = pla_in & ~blk_mask;
endmodule

// File: rtl/bus_idle_pdown_chk.sv
module bus_idle_pdown_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_down,
  input logic       cs_active,
  input logic       chg,
  input logic       en,
  input logic       flash_sel,
  input logic       eeprom_sel,
  input logic       sram_sel,
  input logic       bus_en,
  input logic [5:0] pla_in,
  input logic [5:0] pla_out
);
  // R2
  disabled_no_pd_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwr_down);
  // R3
  rise_after_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> $past(!cs_active && !chg));
  // R5
  edge_release_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && chg) |=> !pwr_down);
  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (rst)
    cs_active |=> !pwr_down);
  // R7
  sel_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> !(flash_sel || eeprom_sel || sram_sel || bus_en));
  // R8
  pla_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_down |-> pla_out == pla_in);
endmodule

bind bus_idle_pdown bus_idle_pdown_chk u_chk (
  .clk(clk), .rst(rst), .pwr_down(pwr_down), .cs_active(cs_active),
  .chg(chg), .en(en), .flash_sel(flash_sel), .eeprom_sel(eeprom_sel),
  .sram_sel(sram_sel), .bus_en(bus_en), .pla_in(pla_in), .pla_out(pla_out)
);

// File: tb/test_bus_idle_pdown.sv
`timescale 1ns/1ps
module test_bus_idle_pdown;
  logic clk = 0, rst = 1;
  logic strobe = 0, cs = 0, wr = 0, sel = 0;
  logic [7:0] wdata = 0;
  logic fl_i = 1, ee_i = 1, sr_i = 1, bu_i = 1;
  logic [5:0] pin = 6'h3F;
  logic pd, fl, ee, sr, bu;
  logic [5:0] pout;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_idle_pdown i_bus_idle_pdown (
    .clk(clk), .rst(rst), .strobe_in(strobe), .cs_active(cs),
    .reg_wr(wr), .reg_sel(sel), .reg_wdata(wdata),
    .flash_sel_in(fl_i), .eeprom_sel_in(ee_i), .sram_sel_in(sr_i),
    .bus_en_in(bu_i), .pla_in(pin), .pwr_down(pd), .flash_sel(fl),
    .eeprom_sel(ee), .sram_sel(sr), .bus_en(bu), .pla_out(pout));

  // behavioural reference
  bit hist[$];
  int mcnt;
  logic [7:0] ma, mb;
  always @(posedge clk) begin
    if (rst) begin
      hist = {1'b0, 1'b0, 1'b0}; mcnt = 0; ma = 0; mb = 0;
    end else begin
      bit act;
      act = cs || (hist[hist.size()-2] != hist[hist.size()-3]);
      if (!ma[1] || act) mcnt = 0;
      else if (mcnt < 15) mcnt++;
      hist.push_back(strobe);
      if (hist.size() > 8) void'(hist.pop_front());
      if (wr) begin
        if (sel) mb = wdata; else ma = wdata;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    logic mpd;
    logic [5:0] mask;
    mpd = (mcnt == 15);
    mask = {mb[6:2], ma[4]} & {6{mpd}};
    chk("R3 pwr_down vs model", pd, mpd);
    chk("R7 selects vs model", {fl, ee, sr, bu},
        {fl_i, ee_i, sr_i, bu_i} & {4{~mpd}});
    chk("R8 pla_out vs model", pout, pin & ~mask);
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(logic s, logic [7:0] d);
    sel = s; wdata = d; wr = 1;
    tick();
    wr = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R1 pwr_down in reset", pd, 0);
    rst = 0;
    tick();
    chk("R1 pla passthrough after reset", pout, 6'h3F);
    chk("R1 selects after reset", {fl, ee, sr, bu}, 4'hF);
    tick(30);
    chk("R2 idle but disabled", pd, 0);

    // enable with pla_in[0] gate; R9 register B write
    wreg(1, 8'h14);
    sel = 0; wdata = 8'h12;
    tick(20);
    chk("R9 no load without reg_wr", pd, 0);
    wreg(0, 8'h12);
    tick(14);
    chk("R3 not yet at E+14", pd, 0);
    tick();
    chk("R3 asserted at E+15", pd, 1);
    chk("R7 selects forced low", {fl, ee, sr, bu}, 4'h0);
    chk("R8 gated mask bits 0,1,3", pout, 6'h34);
    pin = 6'h2A;
    tick();
    chk("R8 gated other pattern", pout, 6'h20);
    pin = 6'h3F;

    // strobe release
    strobe = 1;
    tick();
    chk("R5 still down after N", pd, 1);
    tick();
    chk("R5 still down after N+1", pd, 1);
    tick();
    chk("R4 released after N+2", pd, 0);
    tick(14);
    chk("R4 count restarted", pd, 0);
    tick();
    chk("R3 down again", pd, 1);

    // chip select
    cs = 1;
    tick();
    cs = 0;
    chk("R6 cs releases", pd, 0);
    tick(15);
    chk("R6 count restarted by cs", pd, 1);

    // clear enable while down
    wreg(0, 8'h00);
    chk("R10 still down after write edge", pd, 1);
    tick();
    chk("R10 released next edge", pd, 0);
    tick(25);
    chk("R2 stays off when disabled", pd, 0);

    // register B write does not touch A
    wreg(0, 8'h02);
    wreg(1, 8'h7C);
    tick(20);
    chk("R9 enable survives B write", pd, 1);
    chk("R8 ungated bit 0 with A bit4 clear", pout[0], 1);
    chk("R8 bits 1..5 gated", pout[5:1], 5'h0);

    // toggling faster than limit: never down
    for (int i = 0; i < 12; i++) begin
      strobe = ~strobe;
      tick(10);
      chk("R4 periodic activity prevents pd", pd, 0);
    end
    // slower than limit
    for (int i = 0; i < 4; i++) begin
      strobe = ~strobe;
      tick(22);
      chk("R3 slow activity allows pd", pd, 1);
    end

    // random stretch, model compared every cycle
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 19) == 0) strobe = ~strobe;
      cs = ($urandom_range(0, 63) == 0);
      pin = 6'($urandom);
      {fl_i, ee_i, sr_i, bu_i} = 4'($urandom);
      if ($urandom_range(0, 99) == 0) begin
        sel = 1'($urandom); wdata = 8'($urandom) | 8'h02; wr = 1;
      end else wr = 0;
      tick();
    end
    wr = 0; cs = 0;
    tick(2);
    finish_run();
  end
endmodule